// File: doc/BRIEF.md
# Serial SAR ADC Host Controller

This block is the host side of a three-wire link to a 16-bit successive-approximation converter. A one-cycle start request pulls chip-select low. The block then runs a data clock whose half period is a programmable number of system clocks. The converter uses the first five data-clock periods to sample its input, and the block ignores them. The block then reads a single null bit, which must be zero. After that it shifts in the result, most significant bit first, sampling the data line at each rising data-clock edge.

A bit-count setting lets the host end the frame early to save converter power. After the requested number of bits, the block finishes the clock period, waits one half period and raises chip-select. In the same cycle it pulses `done` with the left-aligned word. Chip-select then stays high for at least one full data-clock period before another frame can begin. If a null bit reads as one, a sticky error flag is set, and the word is still delivered.

Top module: `sar_serial_host`

## Requirements
- R1: While idle, `adc_cs_n` is 1, `busy` is 0 and `adc_sclk` is 0. `adc_sclk` is 0 in every cycle where `adc_cs_n` is 1.
- R2: A `start` seen while idle drives `adc_cs_n` low and `busy` high at the next clock edge. A `start` seen while `busy` is 1 has no effect: it causes neither a second frame nor a second `done`.
- R3: Every data-clock phase lasts exactly H system clocks, where H is `cfg_half` captured at start and a value of 0 counts as 1. This includes the low phase between the chip-select fall and the first rise, and the low phase between the last fall and the chip-select rise.
- R4: Rising edges 1 to 5 of a frame carry no data. Rising edge 6 samples the null bit. Rising edges 7 onward sample result bits 15, 14, 13 and so on, in that order.
- R5: The bit count N is `cfg_bits` captured at start, with 0 clamped to 1 and values above 16 clamped to 16. A frame has exactly 6+N rising data-clock edges.
- R6: `result` is straight binary and left-aligned. Bits 15 down to 16-N hold the received bits, and all lower bits are 0.
- R7: One half period after the last falling data-clock edge, `adc_cs_n` rises. In that same cycle `done` is 1 for exactly one cycle with `result` valid. `result` then holds until the next `done`.
- R8: After chip-select rises, `busy` stays 1 for exactly 2·H cycles, so chip-select is high for at least one data-clock period before the next frame.
- R9: `frame_err` becomes 1 when a null bit samples as 1, stays 1 until reset, and does not prevent that frame's word from being delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion frame |
| cfg_bits | input | 5 | Number of result bits to read (clamped 1..16) |
| cfg_half | input | 8 | Data-clock half period in system clocks (0 acts as 1) |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle strobe, result valid |
| result | output | 16 | Left-aligned conversion word |
| frame_err | output | 1 | Sticky: a null bit read as 1 |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter data clock |
| adc_din | input | 1 | Serial data from converter |

## Verification
The converter model keeps its data line at 1 during the sampling period and after the result. Capturing a bit too early or too late therefore changes the word. The fixed words 0x0000, 0x8000 and 0xFFFF catch stuck and inverted bits. The random words, bit counts from 0 to 19 and half periods from 0 to 3 exercise both clamps and every truncation point of the left-aligned result. Dedicated frames inject a start in the middle of a frame and a null bit read as 1. The frames that follow show that the extra request started nothing and that the error flag stays set while a clean word is still delivered.

// File: rtl/sar_host_pkg.sv
// Shared types for the serial converter host.
// Assumes nothing beyond the state encoding being private to the block.
package sar_host_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // chip-select high, waiting for start
        ST_SETUP,  // chip-select low, clock low before first rise
        ST_RUN,    // data clock toggling
        ST_TAIL,   // clock low after the last fall
        ST_GAP     // chip-select high, minimum off time
    } host_state_e;
endpackage

// File: rtl/sar_half_tick.sv
// Half-period tick generator: pulses tick once every HALF system clocks while en is high.
// Assumes half >= 1 and is held stable while en is high.
module sar_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == half - DIV_W'(1));

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en || tick)  cnt_q <= '0;
        else                   cnt_q <= cnt_q + DIV_W'(1);
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q < half));
endmodule

// File: rtl/sar_bit_capture.sv
// Captures the null bit and the result bits from the serial line at rising-edge numbers.
// Assumes rise_num is the number of the rising edge being made when sample_en is high.
module sar_bit_capture #(
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 5,
    parameter int NULL_RISE   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample_en,
    input  logic [CNT_W-1:0]  rise_num,
    input  logic              din,
    output logic [DATA_W-1:0] word,
    output logic              null_hit
);
    localparam int FIRST_RISE = NULL_RISE + 1;

    logic [DATA_W-1:0] word_q;

    assign word     = word_q;
    // Null bit must read 0; a 1 is reported for the frame-error flag.
    assign null_hit = sample_en && (rise_num == CNT_W'(NULL_RISE)) && din;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam int POS = FIRST_RISE + (DATA_W - 1 - i);
        // Load this result bit on its own rising edge; clear at frame start.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)                                 word_q[i] <= 1'b0;
            else if (sample_en && rise_num == CNT_W'(POS))       word_q[i] <= din;
        end
    end

    p_no_early_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && rise_num < CNT_W'(FIRST_RISE) && !clear) |=> $stable(word_q));
endmodule

// File: rtl/sar_serial_host.sv
// Host controller for a 3-wire SAR converter link: chip-select, data clock, serial data in.
// Frame: SAMPLE_CLKS dead clocks, one null bit (expected 0), then N result bits MSB first,
// sampled on rising data-clock edges. Assumes adc_din is stable near each rising edge.
module sar_serial_host #(
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 8,
    parameter int SAMPLE_CLKS = 5,
    parameter int BITS_W      = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BITS_W-1:0] cfg_bits,
    input  logic [DIV_W-1:0]  cfg_half,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              frame_err,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    input  logic              adc_din
);
    import sar_host_pkg::*;

    localparam int NULL_RISE = SAMPLE_CLKS + 1;
    localparam int CNT_W     = $clog2(NULL_RISE + DATA_W + 2);

    host_state_e       state_q;
    logic              cs_n_q, sclk_q, done_q, ferr_q, gap_q;
    logic [CNT_W-1:0]  rise_q;
    logic [BITS_W-1:0] nbits_q, nbits_clamped;
    logic [DIV_W-1:0]  half_q, half_clamped;
    logic [DATA_W-1:0] result_q, word_w;
    logic              tick_w, accept, sample_en, null_hit;
    logic [CNT_W-1:0]  rise_next, last_rise;

    // Clamp the settings captured at frame start.
    always_comb begin
        if (cfg_bits == '0)                        nbits_clamped = BITS_W'(1);
        else if (cfg_bits > BITS_W'(DATA_W))       nbits_clamped = BITS_W'(DATA_W);
        else                                       nbits_clamped = cfg_bits;
        half_clamped = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
    end

    assign accept    = (state_q == ST_IDLE) && start;
    assign rise_next = rise_q + CNT_W'(1);
    assign last_rise = CNT_W'(NULL_RISE) + CNT_W'(nbits_q);
    assign sample_en = tick_w && (state_q == ST_RUN) && !sclk_q;

    sar_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != ST_IDLE),
        .half  (half_q),
        .tick  (tick_w)
    );

    sar_bit_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W), .NULL_RISE(NULL_RISE)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (sample_en),
        .rise_num  (rise_next),
        .din       (adc_din),
        .word      (word_w),
        .null_hit  (null_hit)
    );

    // Frame sequencer: chip-select, data clock, edge count and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cs_n_q   <= 1'b1;
            sclk_q   <= 1'b0;
            rise_q   <= '0;
            nbits_q  <= BITS_W'(DATA_W);
            half_q   <= DIV_W'(1);
            gap_q    <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_SETUP;
                    cs_n_q  <= 1'b0;
                    rise_q  <= '0;
                    nbits_q <= nbits_clamped;
                    half_q  <= half_clamped;
                end
                ST_SETUP: if (tick_w) begin
                    sclk_q  <= 1'b1;
                    rise_q  <= rise_next;
                    state_q <= ST_RUN;
                end
                ST_RUN: if (tick_w) begin
                    if (sclk_q) begin
                        sclk_q <= 1'b0;
                        if (rise_q == last_rise) state_q <= ST_TAIL;
                    end else begin
                        sclk_q <= 1'b1;
                        rise_q <= rise_next;
                    end
                end
                ST_TAIL: if (tick_w) begin
                    cs_n_q   <= 1'b1;
                    done_q   <= 1'b1;
                    result_q <= word_w;
                    gap_q    <= 1'b0;
                    state_q  <= ST_GAP;
                end
                ST_GAP: if (tick_w) begin
                    if (gap_q) state_q <= ST_IDLE;
                    else       gap_q   <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Sticky framing-error flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        ferr_q <= 1'b0;
        else if (null_hit) ferr_q <= 1'b1;
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign result    = result_q;
    assign frame_err = ferr_q;
    assign adc_cs_n  = cs_n_q;
    assign adc_sclk  = sclk_q;

    p_cs_high_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> adc_cs_n);
    p_sclk_low_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);
    p_sclk_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(adc_sclk) |-> $past(tick_w));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_cs_rise_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> done);
    p_ferr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_err) |-> frame_err);
endmodule

// File: tb/sar_serial_host_tb.sv
// Bench: converter model, timing monitors, directed corners and seeded random frames.
module sar_serial_host_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [4:0]  cfg_bits = 5'd16;
    logic [7:0]  cfg_half = 8'd1;
    logic        busy, done, frame_err, adc_cs_n, adc_sclk;
    logic        adc_din = 1'b1;
    logic [15:0] result;

    int checks = 0, fails = 0;

    sar_serial_host dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_bits(cfg_bits), .cfg_half(cfg_half),
        .busy(busy), .done(done), .result(result), .frame_err(frame_err),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model: data changes on falling edges, 1 outside the null/result window.
    logic [15:0] m_word = '0;
    logic        m_null = 1'b0;
    int          m_falls = 0;
    always @(negedge adc_cs_n) begin m_falls = 0; adc_din = 1'b1; end
    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            m_falls = m_falls + 1;
            if (m_falls == 5)                        adc_din = m_null;
            else if (m_falls >= 6 && m_falls <= 21)  adc_din = m_word[21 - m_falls];
            else                                     adc_din = 1'b1;
        end
    end

    // Monitors: rising edges per frame, done strobes, phase lengths.
    int mon_rises = 0, done_cnt = 0, half_bad = 0, exp_half = 1, gap = 0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    always @(negedge adc_cs_n) mon_rises = 0;
    always @(posedge adc_sclk) if (!adc_cs_n) mon_rises = mon_rises + 1;
    always @(negedge clk) begin
        if (done) done_cnt = done_cnt + 1;
        if (adc_sclk != prev_sclk || adc_cs_n != prev_cs) begin
            if (!(adc_cs_n == 1'b0 && prev_cs == 1'b1) && (gap + 1 != exp_half))
                half_bad = half_bad + 1;
            gap = 0;
        end else gap = gap + 1;
        prev_sclk = adc_sclk;
        prev_cs   = adc_cs_n;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int clamp_bits(input int b);
        return (b == 0) ? 1 : ((b > 16) ? 16 : b);
    endfunction

    function automatic logic [15:0] exp_word(input logic [15:0] w, input int n);
        logic [15:0] mask = 16'hFFFF << (16 - n);
        return w & mask;
    endfunction

    logic exp_ferr = 1'b0;

    task automatic run_frame(input logic [15:0] w, input int bits, input int half,
                             input bit bad_null, input bit extra_start);
        int n, hb0, dc0, busy_cycles;
        logic [15:0] exp;
        n = clamp_bits(bits);
        exp = exp_word(w, n);
        m_word = w; m_null = bad_null;
        cfg_bits = 5'(bits); cfg_half = 8'(half);
        @(negedge clk);
        exp_half = (half == 0) ? 1 : half;
        hb0 = half_bad; dc0 = done_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!adc_cs_n && busy, "R2", "cs low/busy after start", {adc_cs_n, busy}, 2'b01);
        if (extra_start) begin
            repeat (7) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (bad_null) exp_ferr = 1'b1;
        chk(result == exp, "R6", "left-aligned result", result, exp);
        chk(mon_rises == 6 + n, "R5", "rising edges per frame", mon_rises, 6 + n);
        chk(adc_cs_n == 1'b1, "R7", "cs high with done", adc_cs_n, 1);
        chk(frame_err == exp_ferr, "R9", "frame_err", frame_err, exp_ferr);
        chk(half_bad == hb0, "R3", "phase length errors", half_bad - hb0, 0);
        busy_cycles = 0;
        while (busy) begin busy_cycles++; @(negedge clk); end
        chk(busy_cycles == 2 * exp_half, "R8", "cs-high gap cycles", busy_cycles, 2 * exp_half);
        chk(result == exp && !done, "R7", "result held, done single", result, exp);
        if (extra_start) begin
            repeat (8 * exp_half + 4) @(negedge clk);
            chk(adc_cs_n && !busy && done_cnt == dc0 + 1, "R2", "start during busy ignored",
                done_cnt - dc0, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd24601));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n && !adc_sclk && !busy && !done && !frame_err, "R1", "reset state",
            {adc_cs_n, adc_sclk, busy, done, frame_err}, 5'b10000);
        repeat (5) @(negedge clk);
        chk(adc_cs_n && !adc_sclk, "R1", "idle pins", {adc_cs_n, adc_sclk}, 2'b10);
        // Directed corners: codes, bit-count clamps, half-period 0.
        run_frame(16'h0000, 16, 1, 1'b0, 1'b0);   // R4 R6 zero code
        run_frame(16'h8000, 16, 2, 1'b0, 1'b0);   // R4 mid-scale
        run_frame(16'hFFFF, 16, 3, 1'b0, 1'b0);   // R4 full scale
        run_frame(16'hA5C3, 0, 1, 1'b0, 1'b0);    // R5 zero clamps to one bit
        run_frame(16'h5A3C, 31, 2, 1'b0, 1'b0);   // R5 large clamps to 16
        run_frame(16'hFFFF, 3, 0, 1'b0, 1'b0);    // R3 half 0 acts as 1, R6 short frame
        run_frame(16'h1234, 12, 2, 1'b0, 1'b1);   // R2 start while busy ignored
        // Seeded random frames.
        for (int i = 0; i < 40; i++)
            run_frame(16'($urandom), int'($urandom % 20), int'($urandom % 4), 1'b0, 1'b0);
        // R9: bad null sets sticky flag, word still delivered, stays set afterwards.
        run_frame(16'hC0DE, 16, 1, 1'b1, 1'b0);
        run_frame(16'h7FFF, 16, 2, 1'b0, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule